// File: doc/BRIEF.md
# Single-Wire Identity Responder

This block is the responding side of a single-wire, open-drain bus that carries a fixed 64-bit identity. It watches a synchronised copy of the bus level and drives one output that enables an external pull-down transistor. It never drives the bus high. A one-cycle microsecond tick from the surrounding chip times every interval the block uses. The clock only has to be fast enough to see each bus edge.

A long low pulse from the master is a bus reset. The block answers it with a presence pulse and then takes in an 8-bit command through write slots. It then does one of three things. It returns its identity through read slots. It takes part in a bit-by-bit search arbitration. Or it stays off the bus until the next bus reset. Every slot starts with a falling edge driven by the master. A one is sent by leaving the line alone, and a zero is sent by holding it low for a fixed interval.

The identity has three parts: a family byte, a serial field and a check byte. All three are set by parameters. The check byte can either be given outright or be computed while the design is elaborated.

Top module: `sn_wire_slave`

## Requirements
- R1: The identity is 64 bits and is sent least significant bit first. Bits 7:0 hold the family byte (default 01h) and bits 55:8 hold the serial field. Bits 63:56 hold the check byte. With automatic generation, the check byte is the CRC-8 of bits 55:0 using polynomial x^8+x^5+x^4+1, reflected, with initial value 0. As a result, running that CRC over all 64 bits leaves 0.
- R2: A bus low of at least RESET_US (480) µs followed by a rise is a bus reset. The responder then waits between 15 and 60 µs and pulls the line low for between 60 and 240 µs.
- R3: A low shorter than RESET_US, seen while the responder is idle, produces no presence pulse.
- R4: The command is taken from 8 write slots, least significant bit first. Each bit is the bus level SLOT_US (30) µs after the falling edge: low is 0 and high is 1. The responder never pulls the line during command reception.
- R5: After command 33h, each of the next 64 read slots returns the next identity bit. For a 0, the responder pulls the line low from the falling edge for SLOT_US µs. For a 1, it leaves the line alone.
- R6: After command 55h or CCh, the responder pulls the line in no later slot until the next bus reset.
- R7: After any opcode that is not listed in R5, R6, R8 or R12, the responder stays silent until the next bus reset.
- R8: After command F0h, each identity bit uses three slots in this order: a read slot carrying the bit, a read slot carrying its complement, and a write slot. The responder moves on to the next bit when the written value equals its own bit.
- R9: During a search, if the written value differs from the responder's own bit, it stays silent until the next bus reset.
- R10: A bus reset is recognised in every state, including partway through an identity read. The responder then gives a fresh presence pulse and accepts a new command.
- R11: After the last identity bit of a read or a search, the responder stays silent until the next bus reset.
- R12: Command 0Fh behaves exactly like 33h.
- R13: After the synchronous reset input is released, the pull-down stays off and no presence pulse is sent until a bus reset is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| bus_in | input | 1 | Synchronised bus level, 1 is released/high |
| pull_low | output | 1 | Enables the open-drain pull-down when 1 |

## Verification
The pull-down comes on one clock after the clock edge that sees the falling bus level. It goes off SLOT_US ticks later, and a written bit is latched on that same tick. So the bench samples every read slot 15 µs after its own falling edge, halfway through the hold window, at a falling clock edge. Presence is measured as whole microsecond counts after the master releases the line, and the bench checks it against the allowed window rather than one exact cycle. That allows for the one-tick uncertainty in the first interval. Silence after 55h, CCh, an unknown opcode, a lost search or the end of the identity is shown by later read slots, which must all return 1.

// File: rtl/sn_wire_pkg.sv
package sn_wire_pkg;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_PWAIT,
      ST_PDRIVE,
      ST_CMD,
      ST_READ,
      ST_SRCH
   } sn_state_t;

   typedef enum logic [1:0] {
      PH_BIT,
      PH_INV,
      PH_DIR
   } srch_ph_t;

   localparam logic [7:0] OP_READ_A = 8'h33;
   localparam logic [7:0] OP_READ_B = 8'h0F;
   localparam logic [7:0] OP_SEARCH = 8'hF0;
   localparam logic [7:0] OP_MATCH  = 8'h55;
   localparam logic [7:0] OP_SKIP   = 8'hCC;

   // one step of the reflected x^8+x^5+x^4+1 check code
   function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
      logic       fb;
      logic [7:0] n;
      fb = c[0] ^ b;
      n  = c >> 1;
      if (fb) n = n ^ 8'h8C;
      return n;
   endfunction

endpackage

// File: rtl/sn_wire_edge.sv
module sn_wire_edge #(
   parameter int RESET_US = 480,
   parameter int CNT_W    = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic us_tick,
   input  logic bus_in,
   output logic fall,
   output logic bus_rst
);

   localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RESET_US);

   logic             prev_lvl;
   logic [CNT_W-1:0] low_us;

   assign fall    = prev_lvl & ~bus_in;
   assign bus_rst = ~prev_lvl & bus_in & (low_us >= RST_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_lvl <= 1'b1;
         low_us   <= '0;
      end else begin
         prev_lvl <= bus_in;
         if (fall)
            low_us <= '0;
         else if (!bus_in && us_tick && low_us < RST_LIM)
            low_us <= low_us + 1'b1;
      end
   end

endmodule

// File: rtl/sn_wire_rom.sv
module sn_wire_rom import sn_wire_pkg::*; #(
   parameter int              FAM_W    = 8,
   parameter int              SER_W    = 48,
   parameter int              CRC_W    = 8,
   parameter logic [FAM_W-1:0] FAMILY  = 8'h01,
   parameter logic [SER_W-1:0] SERIAL  = 48'h0000_0000_0001,
   parameter bit              CRC_AUTO = 1'b1,
   parameter logic [CRC_W-1:0] CRC_VAL = '0,
   localparam int             BODY_W   = FAM_W + SER_W,
   localparam int             ROM_W    = BODY_W + CRC_W
) (
   output logic [ROM_W-1:0] rom
);

   logic [BODY_W-1:0] body;
   logic [CRC_W-1:0]  chk;

   assign body = {SERIAL, FAMILY};

   generate
      if (CRC_AUTO) begin : g_auto_crc
         if (CRC_W != 8) begin : g_bad_w
            $error("automatic check byte needs CRC_W of 8");
         end
         logic [7:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < BODY_W; i++)
               acc = crc8_step(acc, body[i]);
         end
         assign chk = CRC_W'(acc);
      end else begin : g_fixed_crc
         assign chk = CRC_VAL;
      end
   endgenerate

   assign rom = {chk, body};

endmodule

// File: rtl/sn_wire_ctrl.sv
module sn_wire_ctrl import sn_wire_pkg::*; #(
   parameter int ROM_W        = 64,
   parameter int SLOT_US      = 30,
   parameter int PRES_WAIT_US = 30,
   parameter int PRES_LEN_US  = 120,
   parameter int CNT_W        = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             us_tick,
   input  logic             bus_in,
   input  logic             fall,
   input  logic             bus_rst,
   input  logic [ROM_W-1:0] rom,
   output logic             pull_low,
   output sn_state_t        state_o,
   output logic             slot_act_o
);

   localparam int               IDX_W  = $clog2(ROM_W);
   localparam logic [IDX_W-1:0] LAST   = IDX_W'(ROM_W - 1);
   localparam logic [CNT_W-1:0] T_PW   = CNT_W'(PRES_WAIT_US);
   localparam logic [CNT_W-1:0] T_PL   = CNT_W'(PRES_LEN_US);
   localparam logic [CNT_W-1:0] T_SLOT = CNT_W'(SLOT_US);

   sn_state_t        state;
   srch_ph_t         ph;
   logic [IDX_W-1:0] idx;
   logic [7:0]       cmd;
   logic [2:0]       bitn;
   logic [CNT_W-1:0] cnt;
   logic             slot_act, slot_rd, slot_val;

   logic             cur_bit, rd_now, val_now, slot_done;
   logic [7:0]       cmd_nx;
   sn_state_t        cmd_dst;

   assign cur_bit   = rom[idx];
   assign cmd_nx    = {bus_in, cmd[7:1]};
   assign slot_done = slot_act && (cnt == T_SLOT);

   always_comb begin
      rd_now  = (state == ST_READ) || (state == ST_SRCH && ph != PH_DIR);
      val_now = (state == ST_SRCH && ph == PH_INV) ? ~cur_bit : cur_bit;
   end

   always_comb begin
      case (cmd_nx)
         OP_READ_A, OP_READ_B: cmd_dst = ST_READ;
         OP_SEARCH:            cmd_dst = ST_SRCH;
         OP_MATCH, OP_SKIP:    cmd_dst = ST_WAIT;
         default:              cmd_dst = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_WAIT;
         ph       <= PH_BIT;
         idx      <= '0;
         cmd      <= '0;
         bitn     <= '0;
         cnt      <= '0;
         slot_act <= 1'b0;
         slot_rd  <= 1'b0;
         slot_val <= 1'b1;
      end else if (bus_rst) begin
         state    <= ST_PWAIT;
         cnt      <= '0;
         slot_act <= 1'b0;
      end else begin
         if (us_tick && cnt != '1)
            cnt <= cnt + 1'b1;
         case (state)
            ST_PWAIT: begin
               if (cnt == T_PW) begin
                  state <= ST_PDRIVE;
                  cnt   <= '0;
               end
            end
            ST_PDRIVE: begin
               if (cnt == T_PL) begin
                  state <= ST_CMD;
                  cnt   <= '0;
                  bitn  <= '0;
               end
            end
            ST_CMD, ST_READ, ST_SRCH: begin
               if (!slot_act) begin
                  if (fall) begin
                     slot_act <= 1'b1;
                     cnt      <= '0;
                     slot_rd  <= rd_now;
                     slot_val <= val_now;
                  end
               end else if (slot_done) begin
                  slot_act <= 1'b0;
                  if (state == ST_CMD) begin
                     cmd  <= cmd_nx;
                     bitn <= bitn + 1'b1;
                     if (bitn == 3'd7) begin
                        state <= cmd_dst;
                        idx   <= '0;
                        ph    <= PH_BIT;
                     end
                  end else if (state == ST_READ) begin
                     if (idx == LAST) state <= ST_WAIT;
                     else             idx   <= idx + 1'b1;
                  end else begin
                     case (ph)
                        PH_BIT: ph <= PH_INV;
                        PH_INV: ph <= PH_DIR;
                        default: begin
                           if (bus_in != cur_bit || idx == LAST)
                              state <= ST_WAIT;
                           else begin
                              idx <= idx + 1'b1;
                              ph  <= PH_BIT;
                           end
                        end
                     endcase
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign pull_low   = (state == ST_PDRIVE) | (slot_act & slot_rd & ~slot_val);
   assign state_o    = state;
   assign slot_act_o = slot_act;

endmodule

// File: rtl/sn_wire_slave.sv
module sn_wire_slave import sn_wire_pkg::*; #(
   parameter int              FAM_W        = 8,
   parameter int              SER_W        = 48,
   parameter int              CRC_W        = 8,
   parameter logic [FAM_W-1:0] FAMILY      = 8'h01,
   parameter logic [SER_W-1:0] SERIAL      = 48'h0000_0000_0001,
   parameter bit              CRC_AUTO     = 1'b1,
   parameter logic [CRC_W-1:0] CRC_VAL     = '0,
   parameter int              RESET_US     = 480,
   parameter int              PRES_WAIT_US = 30,
   parameter int              PRES_LEN_US  = 120,
   parameter int              SLOT_US      = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic us_tick,
   input  logic bus_in,
   output logic pull_low
);

   localparam int ROM_W = FAM_W + SER_W + CRC_W;
   localparam int CNT_W = $clog2(RESET_US + 1) + 1;

   if (PRES_WAIT_US < 15 || PRES_WAIT_US > 60) begin : g_chk_pw
      $error("presence wait out of range");
   end
   if (PRES_LEN_US < 60 || PRES_LEN_US > 240) begin : g_chk_pl
      $error("presence length out of range");
   end
   if (SLOT_US < 15 || SLOT_US >= 60) begin : g_chk_slot
      $error("slot sample point out of range");
   end
   if (RESET_US <= PRES_LEN_US) begin : g_chk_rst
      $error("reset threshold must exceed presence length");
   end

   logic             fall, bus_rst, slot_act;
   logic [ROM_W-1:0] rom;
   sn_state_t        state;

   sn_wire_edge #(.RESET_US(RESET_US), .CNT_W(CNT_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_in(bus_in),
      .fall(fall), .bus_rst(bus_rst)
   );

   sn_wire_rom #(
      .FAM_W(FAM_W), .SER_W(SER_W), .CRC_W(CRC_W), .FAMILY(FAMILY),
      .SERIAL(SERIAL), .CRC_AUTO(CRC_AUTO), .CRC_VAL(CRC_VAL)
   ) u_rom (
      .rom(rom)
   );

   sn_wire_ctrl #(
      .ROM_W(ROM_W), .SLOT_US(SLOT_US), .PRES_WAIT_US(PRES_WAIT_US),
      .PRES_LEN_US(PRES_LEN_US), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_in(bus_in),
      .fall(fall), .bus_rst(bus_rst), .rom(rom),
      .pull_low(pull_low), .state_o(state), .slot_act_o(slot_act)
   );

endmodule

// File: rtl/sn_wire_slave_chk.sv
module sn_wire_slave_chk import sn_wire_pkg::*; #(
   parameter int PRES_LEN_US = 120,
   parameter int CNT_W       = 10
) (
   input logic      clk,
   input logic      rst_n,
   input logic      us_tick,
   input logic      bus_in,
   input logic      pull_low,
   input sn_state_t state,
   input logic      slot_act
);

   localparam logic [CNT_W-1:0] PL_MAX = CNT_W'(PRES_LEN_US + 1);

   logic [CNT_W-1:0] drive_us;

   always_ff @(posedge clk) begin
      if (!rst_n)                        drive_us <= '0;
      else if (!pull_low)                drive_us <= '0;
      else if (us_tick && drive_us != '1) drive_us <= drive_us + 1'b1;
   end

   // R2: presence drive never outlasts its configured length
   a_r2_presence_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_low && state == ST_PDRIVE) |-> drive_us <= PL_MAX);

   // R4: no pull-down while the command byte is coming in
   a_r4_quiet_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD) |-> !pull_low);

   // R5: pull-down only inside an open slot or the presence pulse
   a_r5_pull_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
      pull_low |-> (slot_act || state == ST_PDRIVE));

   // R5: a slot drive starts only after the master has taken the line low
   a_r5_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pull_low) && slot_act) |-> !$past(bus_in));

   // R6, R7, R9, R11: parked state never touches the bus
   a_r11_quiet_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> !pull_low);

endmodule

bind sn_wire_slave sn_wire_slave_chk #(.PRES_LEN_US(PRES_LEN_US), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_in(bus_in),
   .pull_low(pull_low), .state(state), .slot_act(slot_act)
);

// File: tb/sn_wire_slave_tb.sv
module sn_wire_slave_tb;

   localparam int          CLK_NS   = 10;
   localparam int          TICK_DIV = 4;
   localparam logic [47:0] SER_T    = 48'h9E41_7D0C_B265;
   localparam logic [55:0] BODY_T   = {SER_T, 8'h01};

   logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, m_low = 1'b0;
   logic pull_low, bus;
   int   n_cmp = 0, n_bad = 0, div = 0;
   logic [63:0] rom_seen = '0;

   assign bus = ~(m_low | pull_low);

   always #(CLK_NS/2) clk = ~clk;

   always @(negedge clk) begin
      div     <= (div == TICK_DIV - 1) ? 0 : div + 1;
      us_tick <= (div == TICK_DIV - 1);
   end

   sn_wire_slave #(.SERIAL(SER_T)) u_dut (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bus_in(bus), .pull_low(pull_low)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic mus(input int n);
      repeat (n * TICK_DIV) @(negedge clk);
   endtask

   // drive a low of len µs, then watch 300 µs for a presence pulse
   task automatic low_and_watch(input int len, output int p_start, output int p_len);
      m_low = 1'b1; mus(len); m_low = 1'b0;
      p_start = -1; p_len = 0;
      for (int t = 0; t < 300; t++) begin
         mus(1);
         if (!bus) begin
            if (p_start < 0) p_start = t;
            p_len++;
         end
      end
   endtask

   task automatic bus_reset(input string req);
      int s, l;
      low_and_watch(500, s, l);
      chk({req, " presence delay in window"}, 64'(s >= 14 && s <= 61), 64'd1);
      chk({req, " presence length in window"}, 64'(l >= 59 && l <= 241), 64'd1);
   endtask

   task automatic wr_bit(input logic b, inout logic saw_pull);
      m_low = 1'b1;
      if (b) begin
         mus(3); m_low = 1'b0; mus(12);
         if (!bus) saw_pull = 1'b1;
         mus(50);
      end else begin
         mus(60); m_low = 1'b0; mus(5);
      end
   endtask

   task automatic rd_bit(output logic b);
      m_low = 1'b1; mus(2); m_low = 1'b0; mus(13);
      b = bus;
      mus(50);
   endtask

   task automatic send_cmd(input logic [7:0] op);
      logic saw = 1'b0;
      for (int i = 0; i < 8; i++) wr_bit(op[i], saw);
      chk("R4 no pull-down during command", 64'(saw), 64'd0);
   endtask

   task automatic t_power_up;
      int s, l;
      chk("R13 pull-down off after reset", 64'(pull_low), 64'd0);
      mus(100);
      chk("R13 no spontaneous presence", 64'(bus), 64'd1);
      low_and_watch(300, s, l);
      chk("R3 short low gives no presence", 64'(l), 64'd0);
   endtask

   task automatic t_read_full;
      logic [7:0] acc;
      logic       b;
      bus_reset("R2");
      send_cmd(8'h33);
      for (int i = 0; i < 64; i++) begin
         rd_bit(b);
         rom_seen[i] = b;
      end
      chk("R1 R5 family and serial", 64'(rom_seen[55:0]), 64'(BODY_T));
      acc = '0;
      for (int i = 0; i < 64; i++)
         acc = {1'b0, acc[7:1]} ^ (((acc[0] ^ rom_seen[i]) != 1'b0) ? 8'h8C : 8'h00);
      chk("R1 check byte closes CRC to zero", 64'(acc), 64'd0);
      rd_bit(b);
      chk("R11 silent after last bit", 64'(b), 64'd1);
   endtask

   task automatic t_silent(input logic [7:0] op, input string req);
      logic [7:0] got;
      logic       b;
      bus_reset(req);
      send_cmd(op);
      for (int i = 0; i < 8; i++) begin
         rd_bit(b);
         got[i] = b;
      end
      chk({req, " no reply after opcode"}, 64'(got), 64'hFF);
   endtask

   task automatic t_search_full;
      logic       b, c;
      logic [63:0] got, inv;
      bus_reset("R8");
      send_cmd(8'hF0);
      for (int i = 0; i < 64; i++) begin
         logic saw = 1'b0;
         rd_bit(b); rd_bit(c);
         got[i] = b; inv[i] = c;
         wr_bit(rom_seen[i], saw);
      end
      chk("R8 search bits", got, rom_seen);
      chk("R8 search complements", inv, ~rom_seen);
      rd_bit(b);
      chk("R11 silent after search end", 64'(b), 64'd1);
   endtask

   task automatic t_search_lose;
      logic b, c, saw;
      logic [3:0] tail;
      saw = 1'b0;
      bus_reset("R9");
      send_cmd(8'hF0);
      for (int i = 0; i < 10; i++) begin
         rd_bit(b); rd_bit(c);
         wr_bit(rom_seen[i], saw);
      end
      rd_bit(b); rd_bit(c);
      chk("R8 bit 10 pair", 64'({b, c}), 64'({rom_seen[10], ~rom_seen[10]}));
      wr_bit(~rom_seen[10], saw);
      for (int i = 0; i < 4; i++) begin
         rd_bit(b);
         tail[i] = b;
      end
      chk("R9 dropped out after mismatch", 64'(tail), 64'hF);
   endtask

   task automatic t_abort;
      logic [19:0] got;
      logic [7:0]  fam;
      logic        b;
      bus_reset("R12");
      send_cmd(8'h0F);
      for (int i = 0; i < 20; i++) begin
         rd_bit(b);
         got[i] = b;
      end
      chk("R12 alternate read opcode", 64'(got), 64'(rom_seen[19:0]));
      bus_reset("R10");
      send_cmd(8'h33);
      for (int i = 0; i < 8; i++) begin
         rd_bit(b);
         fam[i] = b;
      end
      chk("R10 fresh read after mid-read reset", 64'(fam), 64'h01);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_power_up();
      t_read_full();
      t_silent(8'h55, "R6 match");
      t_silent(8'hCC, "R6 skip");
      t_silent(8'hA5, "R7 unknown");
      t_search_full();
      t_search_lose();
      t_abort();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule